// File: doc/BRIEF.md
# CHS Sector Address Sequencer

This block turns a cylinder/head/sector request into a linear block number for a fixed-disk controller. It pulls the request fields out of the command block bytes. It checks the request against the current drive geometry and against where the heads actually sit. It then steps through the sectors of a multi-sector transfer, rolling the sector into the head and the head into the cylinder.

The block also models the head position. A load or a seek moves the heads to the requested cylinder, or to the last track if the request lies beyond it. A recalibrate returns the heads to cylinder 0. A geometry write replaces the track and head counts and forces the track length to 17 sectors.

The controller sequencer drives one strobe at a time. It reads back the block number, an error flag, a one-byte sense code and the number of sectors still to transfer. The media data path and the host handshake are handled elsewhere.

Top module: `chs_seq`

## Requirements
- R1: The request fields are taken from four command bytes. From blk1_i, the head is bits 4:0 and the drive select is bit 5. From blk2_i, the sector is bits 5:0 and cylinder bits 9:8 are bits 7:6. blk3_i holds cylinder bits 7:0 and blk4_i holds the sector count. drv_sel_o shows the drive select of the last load.
- R2: After a load, and after each step that leaves sectors to transfer, lba_o = ((cylinder × heads) + head) × sectors_per_track + sector, with sectors counted from 0. lba_valid_o is high for exactly one cycle, two rising edges after the edge that sampled the strobe.
- R3: A request is illegal if the head position differs from the requested cylinder, if head ≥ heads, or if sector ≥ sectors per track. In that case addr_err_o is 1, lba_o is 0 and sense_o becomes 0x21; a legal request sets sense_o to 0x00.
- R4: A seek sets the requested cylinder from blk2_i/blk3_i. The head position becomes that cylinder, clamped to tracks−1 (or 0 with zero tracks). seek_err_o is 1 and sense_o is 0x15 when the clamped position differs from the request; otherwise seek_err_o is 0 and sense_o is 0x00.
- R5: A load also moves the head position to the clamped requested cylinder and clears seek_err_o.
- R6: Each step increments the sector. At sectors_per_track the sector goes to 0 and the head increments. At the head count the head goes to 0 and the requested cylinder increments, while the head position increments but saturates at tracks−1.
- R7: A count byte of 0 loads 256. Each step decrements remain_o. The step that brings it to 0 does not advance the address and starts no lookup, and done_o (remain_o == 0) goes high. A step while remain_o is 0 changes nothing.
- R8: A recalibrate sets both the requested cylinder and the head position (cur_cyl_o) to 0, clears seek_err_o and sets sense_o to 0x00.
- R9: A geometry write sets tracks to {geo_trk_hi_i, geo_trk_lo_i} and heads to geo_heads_i, and forces 17 sectors per track. Reset loads the default geometry parameters: 615 tracks, 4 heads and 17 sectors. The head position and all state start at 0 and sense_o starts at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk1_i | input | 8 | Command byte with head and drive select |
| blk2_i | input | 8 | Command byte with sector and cylinder high bits |
| blk3_i | input | 8 | Command byte with cylinder low bits |
| blk4_i | input | 8 | Command byte with sector count |
| load_i | input | 1 | Load request, seek and start lookup |
| seek_i | input | 1 | Seek to the command cylinder |
| recal_i | input | 1 | Recalibrate to cylinder 0 |
| step_i | input | 1 | Sector done, advance |
| geo_wr_i | input | 1 | Write drive geometry |
| geo_trk_hi_i | input | 8 | Track count, high byte |
| geo_trk_lo_i | input | 8 | Track count, low byte |
| geo_heads_i | input | 8 | Head count |
| lba_o | output | TRK_W+16 | Linear block number |
| lba_valid_o | output | 1 | One-cycle result strobe |
| addr_err_o | output | 1 | Result is an illegal address |
| sense_o | output | 8 | Last sense code |
| seek_err_o | output | 1 | Last seek missed its target |
| remain_o | output | 9 | Sectors still to transfer |
| done_o | output | 1 | No sectors remain |
| drv_sel_o | output | 1 | Drive select of the last load |
| cur_cyl_o | output | TRK_W | Head position |

## Verification
A wrong sector or head counter appears as a wrong lba_o on the very next step's strobe, two cycles later. A drifting head position shows on cur_cyl_o at once and as a false 0x21 on the next lookup. A count slip shows as remain_o or done_o being off by one after a single step. Roll-over and saturation are driven on purpose with geometries small enough that a short run crosses track and cylinder edges, and random geometry writes move those edges between requests.

// File: rtl/chs_seq_pkg.sv
package chs_seq_pkg;
  localparam int unsigned GEO_W   = 8;
  localparam int unsigned CNT_W   = 9;
  localparam int unsigned CMD_CYL_W = 10;
  localparam logic [7:0] SENSE_OK       = 8'h00;
  localparam logic [7:0] SENSE_BAD_ADDR = 8'h21;
  localparam logic [7:0] SENSE_SEEK_BAD = 8'h15;
  localparam logic [7:0] FIXED_SPT      = 8'd17;

  typedef struct packed {
    logic                 drv;
    logic [4:0]           head;
    logic [5:0]           sec;
    logic [CMD_CYL_W-1:0] cyl;
    logic [7:0]           cnt;
  } cmd_t;

  function automatic cmd_t unpack_cmd(logic [7:0] b1, logic [7:0] b2,
                                      logic [7:0] b3, logic [7:0] b4);
    cmd_t c;
    c.drv  = b1[5];
    c.head = b1[4:0];
    c.sec  = b2[5:0];
    c.cyl  = {b2[7:6], b3};
    c.cnt  = b4;
    return c;
  endfunction
endpackage

// File: rtl/chs_geom.sv
module chs_geom
  import chs_seq_pkg::*;
#(
  parameter int unsigned TRK_W      = 16,
  parameter int unsigned DEF_TRACKS = 615,
  parameter int unsigned DEF_HEADS  = 4,
  parameter int unsigned DEF_SPT    = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       trk_hi_i,
  input  logic [7:0]       trk_lo_i,
  input  logic [GEO_W-1:0] heads_i,
  output logic [TRK_W-1:0] tracks_o,
  output logic [TRK_W-1:0] limit_o,
  output logic [GEO_W-1:0] heads_o,
  output logic [GEO_W-1:0] spt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tracks_o <= TRK_W'(DEF_TRACKS);
      heads_o  <= GEO_W'(DEF_HEADS);
      spt_o    <= GEO_W'(DEF_SPT);
    end else if (wr_i) begin
      tracks_o <= TRK_W'({trk_hi_i, trk_lo_i});
      heads_o  <= heads_i;
      spt_o    <= FIXED_SPT;
    end
  end

  // last reachable cylinder; zero tracks pins the heads at 0
  assign limit_o = (tracks_o == '0) ? '0 : tracks_o - 1'b1;

  AST_GEO_SPT_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> spt_o == FIXED_SPT); // R9
endmodule

// File: rtl/chs_pos.sv
module chs_pos
  import chs_seq_pkg::*;
#(
  parameter int unsigned TRK_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             seek_i,
  input  logic             recal_i,
  input  logic             step_i,
  input  cmd_t             cmd_i,
  input  logic [TRK_W-1:0] limit_i,
  input  logic [GEO_W-1:0] heads_i,
  input  logic [GEO_W-1:0] spt_i,
  output logic [TRK_W-1:0] req_cyl_o,
  output logic [TRK_W-1:0] pos_o,
  output logic [GEO_W-1:0] head_o,
  output logic [GEO_W-1:0] sec_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             drv_o,
  output logic             calc_o,
  output logic             seek_evt_o,
  output logic             seek_err_o
);
  logic [TRK_W-1:0] cyl_ext, cyl_clamp, pos_inc, req_inc;
  logic [GEO_W-1:0] sec_inc, head_inc;
  logic             sec_wrap, head_wrap, step_ok, step_adv;

  assign cyl_ext   = TRK_W'(cmd_i.cyl);
  assign cyl_clamp = (cyl_ext > limit_i) ? limit_i : cyl_ext;
  assign sec_inc   = sec_o + 1'b1;
  assign head_inc  = head_o + 1'b1;
  assign sec_wrap  = sec_inc >= spt_i;
  assign head_wrap = head_inc >= heads_i;
  assign pos_inc   = (pos_o >= limit_i) ? limit_i : pos_o + 1'b1;
  assign req_inc   = (&req_cyl_o) ? req_cyl_o : req_cyl_o + 1'b1;
  assign step_ok   = step_i && (cnt_o != '0);
  assign step_adv  = step_ok && (cnt_o != CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_cyl_o  <= '0;
      pos_o      <= '0;
      head_o     <= '0;
      sec_o      <= '0;
      cnt_o      <= '0;
      drv_o      <= 1'b0;
      calc_o     <= 1'b0;
      seek_evt_o <= 1'b0;
      seek_err_o <= 1'b0;
    end else begin
      calc_o     <= 1'b0;
      seek_evt_o <= 1'b0;
      if (recal_i) begin
        req_cyl_o  <= '0;
        pos_o      <= '0;
        seek_err_o <= 1'b0;
      end else if (seek_i) begin
        req_cyl_o  <= cyl_ext;
        pos_o      <= cyl_clamp;
        seek_err_o <= cyl_clamp != cyl_ext;
        seek_evt_o <= 1'b1;
      end else if (load_i) begin
        req_cyl_o  <= cyl_ext;
        pos_o      <= cyl_clamp;
        head_o     <= GEO_W'(cmd_i.head);
        sec_o      <= GEO_W'(cmd_i.sec);
        drv_o      <= cmd_i.drv;
        cnt_o      <= (cmd_i.cnt == '0) ? CNT_W'(256) : CNT_W'(cmd_i.cnt);
        seek_err_o <= 1'b0;
        calc_o     <= 1'b1;
      end else if (step_ok) begin
        cnt_o <= cnt_o - 1'b1;
        if (step_adv) begin
          calc_o <= 1'b1;
          if (!sec_wrap) begin
            sec_o <= sec_inc;
          end else begin
            sec_o <= '0;
            if (!head_wrap) begin
              head_o <= head_inc;
            end else begin
              head_o    <= '0;
              req_cyl_o <= req_inc;
              pos_o     <= pos_inc;
            end
          end
        end
      end
    end
  end

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !seek_i && !recal_i && cnt_o != '0)
      |=> cnt_o == $past(cnt_o) - 1'b1); // R7
  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !seek_i && !recal_i) |=> cnt_o != '0); // R7
  AST_RECAL_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_i |=> (pos_o == '0 && req_cyl_o == '0)); // R8
  AST_SEEK_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_i && !recal_i) |=> pos_o <= $past(limit_i)); // R4
  AST_SEEK_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_evt_o && !seek_err_o) |-> pos_o == req_cyl_o); // R4
endmodule

// File: rtl/chs_addr.sv
module chs_addr
  import chs_seq_pkg::*;
#(
  parameter int unsigned TRK_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             calc_i,
  input  logic [TRK_W-1:0] req_cyl_i,
  input  logic [TRK_W-1:0] pos_i,
  input  logic [GEO_W-1:0] head_i,
  input  logic [GEO_W-1:0] sec_i,
  input  logic [GEO_W-1:0] heads_i,
  input  logic [GEO_W-1:0] spt_i,
  output logic             chk_v_o,
  output logic             chk_err_o,
  output logic [TRK_W+2*GEO_W-1:0] lba_o,
  output logic             lba_valid_o,
  output logic             addr_err_o
);
  localparam int unsigned T_W   = TRK_W + GEO_W;
  localparam int unsigned LBA_W = T_W + GEO_W;

  logic [T_W-1:0]   trk_q;
  logic [GEO_W-1:0] sec_q, spt_q;

  // stage 1: track index and legality
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_v_o   <= 1'b0;
      chk_err_o <= 1'b0;
      trk_q     <= '0;
      sec_q     <= '0;
      spt_q     <= '0;
    end else begin
      chk_v_o <= calc_i;
      if (calc_i) begin
        trk_q     <= T_W'(req_cyl_i) * T_W'(heads_i) + T_W'(head_i);
        chk_err_o <= (pos_i != req_cyl_i) || (head_i >= heads_i) || (sec_i >= spt_i);
        sec_q     <= sec_i;
        spt_q     <= spt_i;
      end
    end
  end

  // stage 2: scale by track length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lba_valid_o <= 1'b0;
      addr_err_o  <= 1'b0;
      lba_o       <= '0;
    end else begin
      lba_valid_o <= chk_v_o;
      if (chk_v_o) begin
        addr_err_o <= chk_err_o;
        lba_o      <= chk_err_o ? '0
                    : LBA_W'(trk_q) * LBA_W'(spt_q) + LBA_W'(sec_q);
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_i |=> ##1 lba_valid_o); // R2
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lba_valid_o && !chk_v_o) |=> !lba_valid_o); // R2
  AST_ERR_ZERO_LBA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lba_valid_o && addr_err_o) |-> lba_o == '0); // R3
endmodule

// File: rtl/chs_seq.sv
module chs_seq
  import chs_seq_pkg::*;
#(
  parameter int unsigned TRK_W      = 16,
  parameter int unsigned DEF_TRACKS = 615,
  parameter int unsigned DEF_HEADS  = 4,
  parameter int unsigned DEF_SPT    = 17,
  localparam int unsigned LBA_W     = TRK_W + 2*GEO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       blk1_i,
  input  logic [7:0]       blk2_i,
  input  logic [7:0]       blk3_i,
  input  logic [7:0]       blk4_i,
  input  logic             load_i,
  input  logic             seek_i,
  input  logic             recal_i,
  input  logic             step_i,
  input  logic             geo_wr_i,
  input  logic [7:0]       geo_trk_hi_i,
  input  logic [7:0]       geo_trk_lo_i,
  input  logic [7:0]       geo_heads_i,
  output logic [LBA_W-1:0] lba_o,
  output logic             lba_valid_o,
  output logic             addr_err_o,
  output logic [7:0]       sense_o,
  output logic             seek_err_o,
  output logic [CNT_W-1:0] remain_o,
  output logic             done_o,
  output logic             drv_sel_o,
  output logic [TRK_W-1:0] cur_cyl_o
);
  cmd_t             cmd;
  logic [TRK_W-1:0] tracks, limit, req_cyl;
  logic [GEO_W-1:0] heads, spt, head, sec;
  logic             calc, seek_evt, chk_v, chk_err;

  assign cmd = unpack_cmd(blk1_i, blk2_i, blk3_i, blk4_i);

  chs_geom #(
    .TRK_W(TRK_W), .DEF_TRACKS(DEF_TRACKS), .DEF_HEADS(DEF_HEADS), .DEF_SPT(DEF_SPT)
  ) u_geom (
    .clk_i, .rst_ni,
    .wr_i(geo_wr_i), .trk_hi_i(geo_trk_hi_i), .trk_lo_i(geo_trk_lo_i),
    .heads_i(geo_heads_i),
    .tracks_o(tracks), .limit_o(limit), .heads_o(heads), .spt_o(spt)
  );

  chs_pos #(.TRK_W(TRK_W)) u_pos (
    .clk_i, .rst_ni,
    .load_i, .seek_i, .recal_i, .step_i,
    .cmd_i(cmd), .limit_i(limit), .heads_i(heads), .spt_i(spt),
    .req_cyl_o(req_cyl), .pos_o(cur_cyl_o), .head_o(head), .sec_o(sec),
    .cnt_o(remain_o), .drv_o(drv_sel_o), .calc_o(calc),
    .seek_evt_o(seek_evt), .seek_err_o(seek_err_o)
  );

  chs_addr #(.TRK_W(TRK_W)) u_addr (
    .clk_i, .rst_ni,
    .calc_i(calc), .req_cyl_i(req_cyl), .pos_i(cur_cyl_o),
    .head_i(head), .sec_i(sec), .heads_i(heads), .spt_i(spt),
    .chk_v_o(chk_v), .chk_err_o(chk_err),
    .lba_o, .lba_valid_o, .addr_err_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sense_o <= SENSE_OK;
    else if (chk_v)    sense_o <= chk_err ? SENSE_BAD_ADDR : SENSE_OK;
    else if (seek_evt) sense_o <= seek_err_o ? SENSE_SEEK_BAD : SENSE_OK;
    else if (recal_i)  sense_o <= SENSE_OK;
  end

  assign done_o = remain_o == '0;

  AST_DONE_NO_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !seek_i && !recal_i && done_o) |=> (done_o && !calc)); // R7
  AST_SEEK_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_evt && seek_err_o && !chk_v) |=> sense_o == SENSE_SEEK_BAD); // R4
  AST_POS_NOT_PAST_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !seek_i && !recal_i && cur_cyl_o <= limit && !geo_wr_i)
      |=> cur_cyl_o <= $past(limit)); // R6
endmodule

// File: tb/chs_seq_bench.sv
module chs_seq_bench;
  localparam int TRK_W = 16;
  localparam int LBA_W = TRK_W + 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] blk1, blk2, blk3, blk4, g_hi, g_lo, g_hd;
  logic load, seek, recal, step, geo_wr;
  logic [LBA_W-1:0] lba;
  logic lba_valid, addr_err, seek_err, done, drv_sel;
  logic [7:0] sense;
  logic [8:0] remain;
  logic [TRK_W-1:0] cur_cyl;

  chs_seq u_chs_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .blk1_i(blk1), .blk2_i(blk2), .blk3_i(blk3), .blk4_i(blk4),
    .load_i(load), .seek_i(seek), .recal_i(recal), .step_i(step),
    .geo_wr_i(geo_wr), .geo_trk_hi_i(g_hi), .geo_trk_lo_i(g_lo), .geo_heads_i(g_hd),
    .lba_o(lba), .lba_valid_o(lba_valid), .addr_err_o(addr_err), .sense_o(sense),
    .seek_err_o(seek_err), .remain_o(remain), .done_o(done), .drv_sel_o(drv_sel),
    .cur_cyl_o(cur_cyl)
  );

  int checks = 0, fails = 0;
  int m_trk = 615, m_hds = 4, m_spt = 17;
  int m_req = 0, m_pos = 0, m_head = 0, m_sec = 0, m_cnt = 0, m_drv = 0;
  int m_sense = 0, m_serr = 0, m_valid = 0, m_err = 0;
  longint m_lba = 0;

  function automatic int lim();
    return (m_trk == 0) ? 0 : m_trk - 1;
  endfunction

  function automatic int clampc(int c);
    return (c > lim()) ? lim() : c;
  endfunction

  function automatic void m_calc();
    m_valid = 1;
    m_err   = (m_pos != m_req || m_head >= m_hds || m_sec >= m_spt) ? 1 : 0;
    m_lba   = m_err ? 0 : ((longint'(m_req) * m_hds + m_head) * m_spt + m_sec);
    m_sense = m_err ? 'h21 : 'h00;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "lba_valid", 64'(lba_valid), 64'(m_valid));
    if (m_valid != 0) begin
      chk(req, "lba", 64'(lba), 64'(m_lba));
      chk(req, "addr_err", 64'(addr_err), 64'(m_err));
    end
    chk(req, "sense", 64'(sense), 64'(m_sense));
    chk(req, "seek_err", 64'(seek_err), 64'(m_serr));
    chk(req, "remain", 64'(remain), 64'(m_cnt));
    chk(req, "done", 64'(done), 64'(m_cnt == 0));
    chk(req, "cur_cyl", 64'(cur_cyl), 64'(m_pos));
    chk(req, "drv_sel", 64'(drv_sel), 64'(m_drv));
  endtask

  // strobe held over one edge, result sampled two edges later
  task automatic finish_op(string req);
    @(negedge clk);
    load = 0; seek = 0; recal = 0; step = 0; geo_wr = 0;
    @(negedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic put_cyl(int cyl);
    blk2[7:6] = 2'(cyl >> 8);
    blk3      = 8'(cyl);
  endtask

  task automatic do_load(string req, int drv, int hd, int sc, int cyl, int cnt);
    blk1 = {2'b00, 1'(drv), 5'(hd)};
    blk2 = {2'b00, 6'(sc)};
    put_cyl(cyl);
    blk4 = 8'(cnt);
    load = 1;
    m_drv = drv; m_head = hd; m_sec = sc; m_req = cyl; m_pos = clampc(cyl);
    m_cnt = (cnt == 0) ? 256 : cnt; m_serr = 0;
    m_calc();
    finish_op(req);
  endtask

  task automatic do_seek(string req, int cyl);
    blk1 = 8'($urandom); blk2 = 8'($urandom); blk4 = 8'($urandom);
    put_cyl(cyl);
    seek = 1;
    m_req = cyl; m_pos = clampc(cyl);
    m_serr = (m_pos != cyl) ? 1 : 0;
    m_sense = m_serr ? 'h15 : 'h00;
    m_valid = 0;
    finish_op(req);
  endtask

  task automatic do_recal(string req);
    recal = 1;
    m_req = 0; m_pos = 0; m_serr = 0; m_sense = 0; m_valid = 0;
    finish_op(req);
  endtask

  task automatic do_step(string req);
    step = 1;
    m_valid = 0;
    if (m_cnt != 0) begin
      m_cnt--;
      if (m_cnt != 0) begin
        m_sec++;
        if (m_sec >= m_spt) begin
          m_sec = 0;
          m_head++;
          if (m_head >= m_hds) begin
            m_head = 0;
            if (m_req < 65535) m_req++;
            m_pos = (m_pos >= lim()) ? lim() : m_pos + 1;
          end
        end
        m_calc();
      end
    end
    finish_op(req);
  endtask

  task automatic do_geo(string req, int trk, int hds);
    g_hi = 8'(trk >> 8); g_lo = 8'(trk); g_hd = 8'(hds);
    geo_wr = 1;
    m_trk = trk; m_hds = hds; m_spt = 17; m_valid = 0;
    finish_op(req);
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    blk1 = 0; blk2 = 0; blk3 = 0; blk4 = 0; g_hi = 0; g_lo = 0; g_hd = 0;
    load = 0; seek = 0; recal = 0; step = 0; geo_wr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R9_reset");

    // R1 R2: drive 1, cyl 5, head 2, sector 3 -> ((5*4)+2)*17+3 = 377
    do_load("R1_R2", 1, 2, 3, 5, 2);
    do_step("R2_next");
    do_step("R7_last");
    do_step("R7_ignored");
    do_load("R7_zero256", 0, 0, 0, 0, 0);
    // R6: sector and head wrap into cylinder 6
    do_load("R2", 0, 3, 16, 5, 3);
    do_step("R6_wrap");
    do_step("R6_after");
    // R9 R6: shrink to 7 tracks; step past last track saturates position
    do_geo("R9_geo", 7, 4);
    do_load("R2", 0, 3, 16, 6, 3);
    do_step("R6_saturate");
    // R4: seek beyond end, then in range
    do_seek("R4_clamp", 20);
    do_seek("R4_hit", 3);
    // R3: sector and head out of range
    do_load("R3_sector", 0, 0, 17, 3, 1);
    do_load("R3_head", 0, 4, 0, 3, 1);
    // R5: load beyond last track moves heads to the limit, cylinder mismatch
    do_load("R5_R3_cyl", 1, 0, 0, 9, 1);
    do_recal("R8_recal");
    do_load("R8_R2", 0, 1, 1, 0, 1);

    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 11);
      if (op <= 4) do_step("R6_R7_rand");
      else if (op <= 6)
        do_load("R2_R3_rand", $urandom_range(0, 1), $urandom_range(0, m_hds),
                $urandom_range(0, 17), $urandom_range(0, 1023) % (m_trk + 3),
                $urandom_range(0, 5));
      else if (op == 7)
        do_load("R2_rand", $urandom_range(0, 1), $urandom_range(0, m_hds - 1),
                $urandom_range(0, 16), m_pos, $urandom_range(0, 40));
      else if (op == 8) do_seek("R4_rand", $urandom_range(0, 1023) % (m_trk + 4));
      else if (op == 9) do_recal("R8_rand");
      else do_geo("R9_rand", $urandom_range(1, 40), $urandom_range(1, 16));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule